// File: doc/BRIEF.md
# Acknowledged Serial Link Engine

A point-to-point byte link over one output wire and one input wire. A processor hands a byte over a valid/ready pair; the transmitter frames it, shifts it out one bit per bit-enable tick, and then refuses further bytes until the peer answers with an acknowledge packet. Only then does it pulse a completion strobe and reopen its input.

The receiver watches the input wire on the same tick, separates data packets from acknowledge packets by the bit after the start bit, and places each received byte into a one-entry buffer offered to a consumer through valid/ready. Every data packet that arrives is answered with an acknowledge on the output wire. That acknowledge confirms arrival only; it says nothing about whether the byte is correct. Acknowledges share the output wire with outgoing data and are placed only in the gaps between data packets. A byte that arrives while the buffer is still occupied raises an overrun strobe and is discarded.

Top module: `serial_link_engine`

## Requirements
- R1: After reset, and whenever nothing is being sent, line_o is 0; after reset tx_ready_o is 1, rx_valid_o is 0 and overrun_o is 0.
- R2: An accepted byte leaves on line_o as 11 bits, one per tick: a 1 start bit, a 1 type bit, the eight data bits least significant first, then a 0 stop bit. line_o changes only at a clock edge where bit_tick_i is 1.
- R3: An acknowledge packet on line_o is a 1 start bit followed by a 0 type bit; the line then stays 0 until the next packet.
- R4: From the acceptance of a byte until an acknowledge packet is received on line_i, tx_ready_o is 0 and no further data packet starts; on receipt of that acknowledge tx_done_o pulses high for one clock and tx_ready_o returns to 1.
- R5: An acknowledge packet received while no acknowledge is awaited has no effect: no tx_done_o pulse, tx_ready_o unchanged, nothing sent.
- R6: A data packet on line_i (start 1, type 1, eight bits least significant first, stop) sets rx_valid_o with the byte on rx_data_o; both hold until a clock where rx_ready_i is 1, after which rx_valid_o is 0.
- R7: Every data packet received on line_i is answered by exactly one acknowledge packet on line_o, sent after the stop bit and never inside an outgoing data packet.
- R8: A data packet received while rx_valid_o is 1 and rx_ready_i is 0 pulses overrun_o for one clock, leaves rx_data_o at the old byte, and is still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-clock enable marking each bit period |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte on tx_data_i is offered |
| tx_ready_o | output | 1 | Transmitter can take a byte |
| tx_done_o | output | 1 | One-clock pulse when the peer acknowledged the last byte |
| line_o | output | 1 | Serial output wire |
| line_i | input | 1 | Serial input wire |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | rx_data_o holds an unread byte |
| rx_ready_i | input | 1 | Consumer takes the byte |
| overrun_o | output | 1 | One-clock pulse when an arriving byte is dropped |

## Verification
The assertions take for granted that bit_tick_i is a one-clock pulse and that line_i changes only so as to be stable at each ticked edge, with the peer sending a complete packet and never a fresh data packet before it has itself seen an acknowledge. The stimulus holds to this by driving line_i only on the falling edge just ahead of a tick edge from a free-running tick divider, by building whole packets in bench tasks, and by letting the peer send at most one unacknowledged byte. Random bytes come from a fixed seed; directed cases cover stray acknowledges, buffer overrun and an acknowledge that falls due during an outgoing data packet.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_TYPE,
    RX_BITS,
    RX_STOP
  } rx_state_e;

  // value of the bit after the start bit
  localparam logic KIND_DATA = 1'b1;
  localparam logic KIND_ACK  = 1'b0;
endpackage

// File: rtl/link_rx_frame.sv
module link_rx_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_stb_o,
  output logic              ack_stb_o
);
  import link_pkg::*;

  localparam int CW = $clog2(DATA_W + 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      sr_q       <= '0;
      byte_stb_o <= 1'b0;
      ack_stb_o  <= 1'b0;
    end else begin
      byte_stb_o <= 1'b0;
      ack_stb_o  <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (line_i) state_q <= RX_TYPE;
          RX_TYPE: begin
            if (line_i == KIND_DATA) begin
              state_q <= RX_BITS;
              cnt_q   <= '0;
            end else begin
              state_q   <= RX_IDLE;
              ack_stb_o <= 1'b1;
            end
          end
          RX_BITS: begin
            sr_q <= {line_i, sr_q[DATA_W-1:1]};
            if (cnt_q == CW'(DATA_W - 1)) state_q <= RX_STOP;
            else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            state_q    <= RX_IDLE;
            byte_stb_o <= 1'b1;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign byte_o = sr_q;

  // R3: an acknowledge is decoded only from a ticked type bit
  a_r3_ack_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_stb_o |-> $past(tick_i));

  // R6: both packet kinds never complete together
  a_r6_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_stb_o && byte_stb_o));
endmodule

// File: rtl/link_rx_buf.sv
module link_rx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              overrun_o
);
  logic free;
  assign free = !valid_o || rd_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= 1'b0;
      if (wr_i) begin
        if (free) begin
          data_o  <= wr_data_i;
          valid_o <= 1'b1;
        end else begin
          overrun_o <= 1'b1;
        end
      end else if (rd_ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  a_r6_hold_until_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rd_ready_i) |=> (valid_o && $stable(data_o)));

  a_r8_keep_old_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> (valid_o && $stable(data_o)));
endmodule

// File: rtl/link_tx.sv
module link_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_done_o,
  input  logic              ack_req_i,
  input  logic              ack_seen_i,
  output logic              line_o
);
  import link_pkg::*;

  // bits after the start bit: type, data, stop
  localparam int TAIL_W = DATA_W + 2;
  localparam int CW     = $clog2(TAIL_W + 1);

  logic              hold_q, await_q, ack_pend_q;
  logic [DATA_W-1:0] hold_data_q;
  logic [TAIL_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;
  logic              busy, accept, load_ack, load_data;

  assign busy       = (cnt_q != '0);
  assign tx_ready_o = !hold_q && !await_q;
  assign accept     = tx_valid_i && tx_ready_o;
  // acknowledge wins over data at a packet boundary
  assign load_ack   = tick_i && !busy && ack_pend_q;
  assign load_data  = tick_i && !busy && !ack_pend_q && hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= 1'b0;
      hold_data_q <= '0;
      await_q     <= 1'b0;
      ack_pend_q  <= 1'b0;
      tx_done_o   <= 1'b0;
      sh_q        <= '0;
      cnt_q       <= '0;
      line_o      <= 1'b0;
    end else begin
      tx_done_o <= ack_seen_i && await_q;
      if (ack_seen_i) await_q <= 1'b0;
      if (accept) begin
        hold_q      <= 1'b1;
        hold_data_q <= tx_data_i;
      end
      if (load_ack) ack_pend_q <= 1'b0;
      if (ack_req_i) ack_pend_q <= 1'b1;

      if (tick_i) begin
        if (busy) begin
          line_o <= sh_q[0];
          sh_q   <= sh_q >> 1;
          cnt_q  <= cnt_q - 1'b1;
        end else if (load_ack) begin
          line_o <= 1'b1;
          sh_q   <= TAIL_W'(KIND_ACK);
          cnt_q  <= CW'(1);
        end else if (load_data) begin
          line_o  <= 1'b1;
          sh_q    <= {1'b0, hold_data_q, KIND_DATA};
          cnt_q   <= CW'(TAIL_W);
          hold_q  <= 1'b0;
          await_q <= 1'b1;
        end else begin
          line_o <= 1'b0;
        end
      end
    end
  end

  a_r2_line_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(line_o));

  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);

  a_r4_done_reopens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> !await_q);

  a_r7_ack_not_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/serial_link_engine.sv
module serial_link_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_done_o,
  output logic              line_o,
  input  logic              line_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              overrun_o
);
  logic [DATA_W-1:0] rx_byte;
  logic              rx_byte_stb, rx_ack_stb;

  link_rx_frame #(.DATA_W(DATA_W)) u_rx_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (bit_tick_i),
    .line_i     (line_i),
    .byte_o     (rx_byte),
    .byte_stb_o (rx_byte_stb),
    .ack_stb_o  (rx_ack_stb)
  );

  link_rx_buf #(.DATA_W(DATA_W)) u_rx_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (rx_byte_stb),
    .wr_data_i  (rx_byte),
    .rd_ready_i (rx_ready_i),
    .data_o     (rx_data_o),
    .valid_o    (rx_valid_o),
    .overrun_o  (overrun_o)
  );

  link_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (bit_tick_i),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .tx_done_o  (tx_done_o),
    .ack_req_i  (rx_byte_stb),
    .ack_seen_i (rx_ack_stb),
    .line_o     (line_o)
  );
endmodule

// File: tb/tb_serial_link_engine.sv
module tb_serial_link_engine;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_done, line_o;
  logic       line_i = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       overrun;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] tcnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0; else tcnt <= tcnt + 1'b1;
  assign bit_tick = (tcnt == 2'd0);

  serial_link_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(bit_tick),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_done_o(tx_done), .line_o(line_o), .line_i(line_i),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .overrun_o(overrun)
  );

  // peer-side decoder of line_o, sampled after each ticked edge
  logic tick_d;
  always @(posedge clk) tick_d <= bit_tick;

  int   ds = 0, bi = 0;
  logic [7:0] cur;
  logic [7:0] got_q[$];
  int   data_out = 0, ack_out = 0, frame_err = 0, ack_at_data = 0;
  int   done_cnt = 0, ovr_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_done) done_cnt++;
      if (overrun) ovr_cnt++;
      if (tick_d) begin
        case (ds)
          0: if (line_o) ds = 1;
          1: if (line_o) begin ds = 2; bi = 0; end
             else begin ack_out++; ack_at_data = data_out; ds = 0; end
          2: begin cur[bi] = line_o; bi++; if (bi == 8) ds = 3; end
          default: begin
            if (line_o) frame_err++;
            got_q.push_back(cur); data_out++; ds = 0;
          end
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk);
    while (!bit_tick) @(negedge clk);
    line_i = b;
    @(negedge clk);
  endtask

  task automatic send_ack();
    put_bit(1'b1); put_bit(1'b0);
  endtask

  task automatic send_data(input logic [7:0] b);
    put_bit(1'b1); put_bit(1'b1);
    for (int i = 0; i < 8; i++) put_bit(b[i]);
    put_bit(1'b0);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic offer(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic wait_data(input int n);
    for (int k = 0; k < 400 && data_out < n; k++) @(negedge clk);
  endtask

  // one full transmit round trip with checks
  task automatic tx_round(input logic [7:0] b, input bit probe);
    int d0, c0;
    d0 = data_out; c0 = done_cnt;
    offer(b);
    check(tx_ready == 1'b0, "R4 ready low after accept", tx_ready, 0);
    wait_data(d0 + 1);
    check(got_q.size() > 0 && got_q[$] == b, "R2 data bits", got_q.size() ? got_q[$] : 0, b);
    check(frame_err == 0, "R2 stop bit", frame_err, 0);
    if (probe) begin
      @(negedge clk); tx_data = ~b; tx_valid = 1'b1;
      wait_ticks(20);
      check(data_out == d0 + 1, "R4 no packet before ack", data_out, d0 + 1);
      check(done_cnt == c0, "R4 no done before ack", done_cnt, c0);
      tx_valid = 1'b0;
    end
    send_ack();
    wait_ticks(2);
    check(done_cnt == c0 + 1, "R4 done pulse on ack", done_cnt, c0 + 1);
    check(tx_ready == 1'b1, "R4 ready after ack", tx_ready, 1);
  endtask

  task automatic rx_round(input logic [7:0] b);
    int a0;
    a0 = ack_out;
    send_data(b);
    wait_ticks(4);
    check(rx_valid == 1'b1, "R6 valid", rx_valid, 1);
    check(rx_data == b, "R6 data", rx_data, b);
    check(ack_out == a0 + 1, "R7 ack sent", ack_out, a0 + 1);
    wait_ticks(3);
    check(rx_valid == 1'b1 && rx_data == b, "R6 held", rx_data, b);
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    check(rx_valid == 1'b0, "R6 taken", rx_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] x, y;
    int a0, d0, o0, c0;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check(line_o == 1'b0 && tx_ready == 1'b1, "R1 reset line/ready", {line_o, tx_ready}, 1);
    check(rx_valid == 1'b0 && overrun == 1'b0, "R1 reset rx", {rx_valid, overrun}, 0);
    rst_n = 1'b1;
    wait_ticks(6);
    check(line_o == 1'b0 && data_out == 0 && ack_out == 0, "R1 idle low", line_o, 0);

    // R2 R4 directed and random
    tx_round(8'hA5, 1'b1);
    tx_round(8'h01, 1'b0);
    tx_round(8'h80, 1'b0);
    for (int i = 0; i < 10; i++) tx_round(8'($urandom), 1'b0);

    // R5 stray acknowledge
    c0 = done_cnt; d0 = data_out;
    send_ack();
    wait_ticks(4);
    check(done_cnt == c0, "R5 no done", done_cnt, c0);
    check(tx_ready == 1'b1 && data_out == d0 && line_o == 1'b0, "R5 no effect", tx_ready, 1);

    // R6 R7 R3 receive path
    a0 = ack_out;
    rx_round(8'h3C);
    for (int i = 0; i < 6; i++) rx_round(8'($urandom));
    check(frame_err == 0 && ack_out == a0 + 7, "R3 ack frames", ack_out, a0 + 7);

    // R8 overrun
    x = 8'h5E; y = 8'hC1;
    a0 = ack_out; o0 = ovr_cnt;
    send_data(x); wait_ticks(4);
    send_data(y); wait_ticks(4);
    check(ovr_cnt == o0 + 1, "R8 overrun pulse", ovr_cnt, o0 + 1);
    check(rx_data == x && rx_valid == 1'b1, "R8 old byte kept", rx_data, x);
    check(ack_out == a0 + 2, "R8 still acked", ack_out, a0 + 2);
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;

    // R7 ack due during an outgoing data packet
    x = 8'h96; y = 8'h4B;
    a0 = ack_out; d0 = data_out;
    fork
      send_data(y);
      begin wait_ticks(8); offer(x); end
    join
    wait_data(d0 + 1);
    wait_ticks(4);
    check(got_q[$] == x && frame_err == 0, "R7 data intact", got_q[$], x);
    check(ack_out == a0 + 1, "R7 one ack", ack_out, a0 + 1);
    check(ack_at_data == d0 + 1, "R7 ack after data packet", ack_at_data, d0 + 1);
    check(rx_data == y, "R6 concurrent rx", rx_data, y);
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    c0 = done_cnt;
    send_ack(); wait_ticks(2);
    check(done_cnt == c0 + 1, "R4 done after interleave", done_cnt, c0 + 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule